// File: doc/BRIEF.md
# Peripheral Slowdown Delay Controller

This block raises a temporary slow-mode request while an accelerated processor touches peripherals whose software depends on fixed timing. Four local sources (paddle, counter, external, speaker) and a parameterised number of expansion slots each have an access strobe and a delay-enable bit. An enabled access loads a hold counter with that source's hold time. Local sources use a short hold. Slot sources use a long hold.

The counter counts down only on a single-cycle millisecond tick, which is an input to the block. The slow flag that status logic reads is simply "counter non-zero". A new access during a running delay never shortens it: the counter takes the larger of what is left and the new hold. Any write into the control register window cancels the delay at once, whether the registers are locked or not. The clock switch that acts on the flag is outside this block.

All pins are plain control and status strobes. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `slowdn_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `slow_active` is 0.
- R2: An access on `paddle_hit`, `counter_hit`, `ext_hit` or `spkr_hit` whose enable bit is 1 sets `slow_active` from the next cycle on. The flag then stays 1 until exactly LOCAL_HOLD ticks have been counted.
- R3: An access on `slot_hit[k]` whose slot enable bit is 1 sets `slow_active` from the next cycle on. The flag then stays 1 until exactly SLOT_HOLD ticks have been counted.
- R4: In `slot_spk_en`, bit k (1..NUM_SLOTS) enables slot k and bit 0 enables the speaker. `slot_hit` bit k belongs to slot k.
- R5: An access from a source whose enable bit is 0 has no effect on `slow_active` or on the remaining delay.
- R6: An enabled access during a running delay sets the remaining count to the larger of (the remaining count, less one if a tick falls in that cycle) and the new hold. A shorter hold never cuts a longer delay.
- R7: `ctrl_wr` clears the delay, and `slow_active` is 0 on the next cycle. This holds even when an enabled access or a tick arrives in the same cycle.
- R8: With no access and no control write, the remaining count drops by one on each cycle with `tick_ms` high and is held otherwise. `slow_active` is 1 exactly while the count is non-zero.
- R9: The remaining count never exceeds the larger of LOCAL_HOLD and SLOT_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| paddle_hit | input | 1 | Paddle access strobe |
| counter_hit | input | 1 | Counter access strobe |
| ext_hit | input | 1 | External delay request strobe |
| spkr_hit | input | 1 | Speaker access strobe |
| slot_hit | input | NUM_SLOTS | Slot access strobes, bit k = slot k |
| paddle_dly_en | input | 1 | Paddle delay enable |
| counter_dly_en | input | 1 | Counter delay enable |
| ext_dly_en | input | 1 | External delay enable |
| slot_spk_en | input | NUM_SLOTS+1 | Bit k enables slot k, bit 0 enables speaker |
| ctrl_wr | input | 1 | Write strobe to the control register window (cancels delay) |
| slow_active | output | 1 | 1 while a delay is in effect |

## Verification
The bench builds the block with LOCAL_HOLD=3, SLOT_HOLD=15 and seven slots. With these values the derived counter is four bits wide and the slot hold is its all-ones value, so any overflow or width slip in the max-merge shows up at once. The short holds let every slot, every local source, retriggers in both directions and a cancel that coincides with an access and a tick all fit into a few thousand cycles. Ticks arrive every fourth clock, so accesses land both on and off tick cycles.

// File: rtl/slowdn_pkg.sv
package slowdn_pkg;
  // Index of each local source inside the local strobe vector.
  localparam int LOC_PADDLE  = 0;
  localparam int LOC_COUNTER = 1;
  localparam int LOC_EXT     = 2;
  localparam int LOC_SPKR    = 3;
  localparam int NUM_LOCAL   = 4;

  // Bit of the slot/speaker enable register that holds the speaker enable.
  localparam int SPKR_EN_BIT = 0;

  function automatic int hold_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/slowdn_qualify.sv
// Gates raw access strobes with their enable bits.
module slowdn_qualify #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  input  logic [N-1:0] en,
  output logic [N-1:0] fire
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign fire[i] = hit[i] & en[i];
  end
endmodule

// File: rtl/slowdn_req_merge.sv
// Picks the largest hold value among the sources firing this cycle.
module slowdn_req_merge #(
  parameter int NSRC  = 11,
  parameter int CNT_W = 6
) (
  input  logic [NSRC-1:0]            fire,
  input  logic [NSRC-1:0][CNT_W-1:0] hold_vals,
  output logic [CNT_W-1:0]           req
);
  logic [NSRC:0][CNT_W-1:0] stage;
  assign stage[0] = '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    logic [CNT_W-1:0] cand;
    assign cand         = fire[i] ? hold_vals[i] : '0;
    assign stage[i + 1] = (cand > stage[i]) ? cand : stage[i];
  end

  assign req = stage[NSRC];
endmodule

// File: rtl/slowdn_hold_counter.sv
// Remaining-delay counter: cancel wins, otherwise max(decremented, request).
module slowdn_hold_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             tick,
  input  logic [CNT_W-1:0] req,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    dec = cnt;
    if (tick && (cnt != '0)) dec = cnt - 1'b1;
    nxt = (req > dec) ? req : dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cancel) cnt <= '0;
    else             cnt <= nxt;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/slowdn_ctrl.sv
module slowdn_ctrl #(
  parameter int LOCAL_HOLD = 5,
  parameter int SLOT_HOLD  = 53,
  parameter int NUM_SLOTS  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_ms,
  input  logic                 paddle_hit,
  input  logic                 counter_hit,
  input  logic                 ext_hit,
  input  logic                 spkr_hit,
  input  logic [NUM_SLOTS:1]   slot_hit,
  input  logic                 paddle_dly_en,
  input  logic                 counter_dly_en,
  input  logic                 ext_dly_en,
  input  logic [NUM_SLOTS:0]   slot_spk_en,
  input  logic                 ctrl_wr,
  output logic                 slow_active
);
  import slowdn_pkg::*;

  localparam int HOLD_MAX = hold_max(LOCAL_HOLD, SLOT_HOLD);
  localparam int CNT_W    = cnt_width(HOLD_MAX);
  localparam int NSRC     = NUM_LOCAL + NUM_SLOTS;

  logic [NUM_LOCAL-1:0] loc_hit, loc_en, loc_fire;
  logic [NUM_SLOTS-1:0] slt_hit, slt_en, slt_fire;

  assign loc_hit[LOC_PADDLE]  = paddle_hit;
  assign loc_hit[LOC_COUNTER] = counter_hit;
  assign loc_hit[LOC_EXT]     = ext_hit;
  assign loc_hit[LOC_SPKR]    = spkr_hit;
  assign loc_en[LOC_PADDLE]   = paddle_dly_en;
  assign loc_en[LOC_COUNTER]  = counter_dly_en;
  assign loc_en[LOC_EXT]      = ext_dly_en;
  assign loc_en[LOC_SPKR]     = slot_spk_en[SPKR_EN_BIT];

  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_slot_map
    assign slt_hit[k - 1] = slot_hit[k];
    assign slt_en[k - 1]  = slot_spk_en[k];
  end

  slowdn_qualify #(.N(NUM_LOCAL)) u_loc_q (
    .hit (loc_hit),
    .en  (loc_en),
    .fire(loc_fire)
  );

  slowdn_qualify #(.N(NUM_SLOTS)) u_slt_q (
    .hit (slt_hit),
    .en  (slt_en),
    .fire(slt_fire)
  );

  logic [NSRC-1:0]            all_fire;
  logic [NSRC-1:0][CNT_W-1:0] hold_vals;

  assign all_fire = {slt_fire, loc_fire};

  for (genvar i = 0; i < NSRC; i++) begin : g_hold
    if (i < NUM_LOCAL) begin : g_local
      assign hold_vals[i] = CNT_W'(LOCAL_HOLD);
    end else begin : g_slot
      assign hold_vals[i] = CNT_W'(SLOT_HOLD);
    end
  end

  logic [CNT_W-1:0] req;

  slowdn_req_merge #(.NSRC(NSRC), .CNT_W(CNT_W)) u_merge (
    .fire     (all_fire),
    .hold_vals(hold_vals),
    .req      (req)
  );

  logic [CNT_W-1:0] hold_cnt;

  slowdn_hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cancel(ctrl_wr),
    .tick  (tick_ms),
    .req   (req),
    .cnt   (hold_cnt),
    .busy  (slow_active)
  );
endmodule

// File: rtl/slowdn_ctrl_chk.sv
module slowdn_ctrl_chk #(
  parameter int LOCAL_HOLD = 5,
  parameter int SLOT_HOLD  = 53,
  parameter int NUM_SLOTS  = 7,
  parameter int CNT_W      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_ms,
  input logic               paddle_hit,
  input logic               counter_hit,
  input logic               ext_hit,
  input logic               spkr_hit,
  input logic [NUM_SLOTS:1] slot_hit,
  input logic               paddle_dly_en,
  input logic               counter_dly_en,
  input logic               ext_dly_en,
  input logic [NUM_SLOTS:0] slot_spk_en,
  input logic               ctrl_wr,
  input logic               slow_active,
  input logic [CNT_W-1:0]   hold_cnt
);
  logic loc_go, slt_go;
  assign loc_go = (paddle_hit & paddle_dly_en) | (counter_hit & counter_dly_en) |
                  (ext_hit & ext_dly_en) | (spkr_hit & slot_spk_en[0]);
  assign slt_go = |(slot_hit & slot_spk_en[NUM_SLOTS:1]);

  localparam int MAXH = (LOCAL_HOLD > SLOT_HOLD) ? LOCAL_HOLD : SLOT_HOLD;

  assert_local_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_go && !ctrl_wr) |=> slow_active);

  assert_slot_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slt_go && !ctrl_wr) |=> (hold_cnt >= CNT_W'(SLOT_HOLD)));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_go && !slt_go && !ctrl_wr && !tick_ms) |=> $stable(hold_cnt));

  assert_never_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((loc_go || slt_go) && !ctrl_wr && !tick_ms) |=> (hold_cnt >= $past(hold_cnt)));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !slow_active);

  assert_tick_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && hold_cnt != '0 && !loc_go && !slt_go && !ctrl_wr)
      |=> (hold_cnt == $past(hold_cnt) - 1'b1));

  assert_flag_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slow_active == (hold_cnt != '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= CNT_W'(MAXH));
endmodule

bind slowdn_ctrl slowdn_ctrl_chk #(
  .LOCAL_HOLD(LOCAL_HOLD), .SLOT_HOLD(SLOT_HOLD),
  .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
  .paddle_hit(paddle_hit), .counter_hit(counter_hit),
  .ext_hit(ext_hit), .spkr_hit(spkr_hit), .slot_hit(slot_hit),
  .paddle_dly_en(paddle_dly_en), .counter_dly_en(counter_dly_en),
  .ext_dly_en(ext_dly_en), .slot_spk_en(slot_spk_en),
  .ctrl_wr(ctrl_wr), .slow_active(slow_active), .hold_cnt(hold_cnt)
);

// File: tb/slowdn_ctrl_bench.sv
`timescale 1ns/1ps
module slowdn_ctrl_bench;
  localparam int LH = 3;
  localparam int SH = 15;
  localparam int NS = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n = 1'b0;
  logic          tick_ms = 1'b0;
  logic          paddle_hit = 1'b0, counter_hit = 1'b0, ext_hit = 1'b0, spkr_hit = 1'b0;
  logic [NS:1]   slot_hit = '0;
  logic          paddle_dly_en = 1'b0, counter_dly_en = 1'b0, ext_dly_en = 1'b0;
  logic [NS:0]   slot_spk_en = '0;
  logic          ctrl_wr = 1'b0;
  logic          slow_active;

  slowdn_ctrl #(.LOCAL_HOLD(LH), .SLOT_HOLD(SH), .NUM_SLOTS(NS)) u_slowdn_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .paddle_hit(paddle_hit), .counter_hit(counter_hit), .ext_hit(ext_hit),
    .spkr_hit(spkr_hit), .slot_hit(slot_hit),
    .paddle_dly_en(paddle_dly_en), .counter_dly_en(counter_dly_en),
    .ext_dly_en(ext_dly_en), .slot_spk_en(slot_spk_en),
    .ctrl_wr(ctrl_wr), .slow_active(slow_active)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    m_cnt = 0;
  int    cyc = 0;
  bit    auto_tick = 1'b1;
  bit    done = 1'b0;
  string tag = "R1";

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: slow_active=%b expected %b", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference: apply the requirements to the inputs seen at this edge.
  task automatic model_edge();
    int rem, want;
    if (!rst_n || ctrl_wr) begin
      m_cnt = 0;
      return;
    end
    rem = m_cnt;
    if (tick_ms && rem > 0) rem = rem - 1;
    want = 0;
    if ((paddle_hit && paddle_dly_en) || (counter_hit && counter_dly_en) ||
        (ext_hit && ext_dly_en) || (spkr_hit && slot_spk_en[0])) want = LH;
    for (int k = 1; k <= NS; k++)
      if (slot_hit[k] && slot_spk_en[k] && SH > want) want = SH;
    m_cnt = (want > rem) ? want : rem;
  endtask

  task automatic clear_strobes();
    paddle_hit = 0; counter_hit = 0; ext_hit = 0; spkr_hit = 0;
    slot_hit = '0; ctrl_wr = 0; tick_ms = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      if (auto_tick && (cyc % 4 == 3)) tick_ms = 1'b1;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cyc++;
      check(tag, slow_active, (m_cnt != 0));
      clear_strobes();
    end
  endtask

  task automatic cancel();
    ctrl_wr = 1'b1;
    run(1);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    check("R1", slow_active, 1'b0);
    run(3);
    rst_n = 1'b1;
    tag = "R1";
    run(2);

    // R2: each enabled local source
    tag = "R2";
    paddle_dly_en = 1; counter_dly_en = 1; ext_dly_en = 1; slot_spk_en = 8'h01;
    paddle_hit = 1;  run(20);
    counter_hit = 1; run(20);
    ext_hit = 1;     run(3); spkr_hit = 1; run(20);

    // R3: each slot on its own
    tag = "R3";
    slot_spk_en = '1;
    for (int k = 1; k <= NS; k++) begin
      slot_hit[k] = 1'b1;
      run(66);
    end

    // R4: bit mapping, only slot 3 enabled, speaker disabled
    tag = "R4";
    slot_spk_en = 8'b0000_1000;
    slot_hit[4] = 1; run(3);
    slot_hit[2] = 1; spkr_hit = 1; run(3);
    slot_hit[3] = 1; run(10); cancel();
    slot_spk_en = 8'b0000_0001;
    spkr_hit = 1; slot_hit = '1; run(16);

    // R5: all enables clear
    tag = "R5";
    slot_spk_en = '0; paddle_dly_en = 0; counter_dly_en = 0; ext_dly_en = 0;
    paddle_hit = 1; counter_hit = 1; ext_hit = 1; spkr_hit = 1; slot_hit = '1;
    run(8);
    paddle_dly_en = 1; paddle_hit = 1; run(2);
    paddle_dly_en = 0; paddle_hit = 1; slot_hit = '1; run(20);

    // R6: retrigger in both directions
    tag = "R6";
    slot_spk_en = '1; paddle_dly_en = 1;
    slot_hit[5] = 1; run(20);
    paddle_hit = 1;  run(30);
    paddle_hit = 1;  run(6);
    slot_hit[1] = 1; run(9);
    slot_hit[7] = 1; run(70);

    // R7: cancel, including with simultaneous access and tick
    tag = "R7";
    slot_hit[2] = 1; run(10);
    cancel(); run(5);
    slot_hit[6] = 1; run(4);
    auto_tick = 0;
    ctrl_wr = 1; tick_ms = 1; slot_hit[6] = 1; paddle_hit = 1; run(1);
    run(4);
    auto_tick = 1;

    // R8/R9: random traffic
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      paddle_dly_en = r[0]; counter_dly_en = r[1]; ext_dly_en = r[2];
      slot_spk_en = r[10:3];
      if (r[13:11] == 0) paddle_hit = 1;
      if (r[16:14] == 0) counter_hit = 1;
      if (r[19:17] == 0) ext_hit = 1;
      if (r[22:20] == 0) spkr_hit = 1;
      if (r[27:23] == 0) slot_hit = NS'($urandom);
      if (r[31:28] == 0) ctrl_wr = 1;
      tag = (i % 2 == 0) ? "R8" : "R9";
      run(1);
    end
    run(70);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule